// File: doc/BRIEF.md
# Vector convolution accumulate engine

The engine carries out one convolution-accumulate operation, fusing an im2col gather with a small matrix multiply. A 32-bit command word selects a range of filter indices, two 9-bit signed biases and the signedness of each 8-bit operand. For every filter index in the range, each of eight image rows is multiplied byte-wise against one full filter register. The image word that matches the filter index is transposed and broadcast across all filter words. The biased products are added into an 8x8 array of 32-bit accumulators. The existing contents are kept, so several operations can be chained before the results are read out.

The accumulators are stored in an interleaved double-widening layout. Later reduction steps, which sit outside this block, read them back in order. Software clears the array through a dedicated clear input, can load a row through a write port, and reads rows through a combinational read port. Operand registers are fetched through a valid/ready read port. `rd_valid` is high for every cycle the engine is busy. A beat, meaning one image row against one filter register, completes on each rising edge where `rd_valid` and `rd_ready` are both high. While `rd_ready` is low the engine holds its selects and makes no accumulator update. The register file returns `rd_narrow_data` and `rd_wide_data` in the same cycle as the selects.

Top module: `conv_acc_engine`

## Requirements
- R1: Command fields are mode [31:30], first filter index [29:25], last filter index [24:20], bias1 [19:11], data1-signed [10], bias2 [9:1] and data2-signed [0]. For a legal command, every step adds (data1 + bias1) * (data2 + bias2) to the target accumulator, wrapping at 32 bits, on top of its existing value.
- R2: When mode is not 0, `done` and `illegal` pulse together in the cycle after start is taken, and no accumulator changes.
- R3: When first > last, first >= 8 or last >= 8, `done` and `illegal` pulse together in the cycle after start is taken, and no accumulator changes.
- R4: Both bias fields are sign-extended from 9 bits. A data byte is two's complement when its signed bit is 1 and unsigned otherwise.
- R5: For filter index k, the engine reads wide register k - first. For narrow row i (0..7) and wide byte j (0..31), it uses narrow byte 4k + (j mod 4). Byte n of a 256-bit register sits at bits [8n+7:8n].
- R6: A product lands in accumulator row (i with its two low bits cleared) + P[(j/4) mod 4], with P = 0,2,1,3, and in column (i mod 4)*2 + j/16.
- R7: A legal operation of L = last - first + 1 filters makes 8L beats. `busy` is high from the cycle after start until the last beat. `done` pulses for one cycle right after the last beat, with `illegal` low. A start while busy is ignored.
- R8: When `rd_ready` is low during a busy cycle, the selects hold, no accumulation occurs, and the run lasts one cycle longer.
- R9: `acc_clear` zeroes all 64 accumulators when idle. `acc_clear` and `acc_wr_en` are ignored while busy.
- R10: `acc_wr_en` loads row `acc_wr_row` from `acc_wr_data` when idle. `acc_rd_data` shows row `acc_rd_row` combinationally, with column c at bits [32c+31:32c].
- R11: Synchronous reset clears `busy`, `done` and `illegal` but leaves the accumulators unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation with `cmd` (taken when not busy) |
| cmd | input | 32 | Command word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Rejected command, pulses with `done` |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Register file accepts the read this cycle |
| rd_narrow_sel | output | 3 | Narrow (image) register offset, equal to row i |
| rd_wide_sel | output | 3 | Wide (filter) register offset, k - first |
| rd_narrow_data | input | 256 | Narrow register contents |
| rd_wide_data | input | 256 | Wide register contents |
| acc_clear | input | 1 | Zero all accumulators |
| acc_wr_en | input | 1 | Write one accumulator row |
| acc_wr_row | input | 3 | Row to write |
| acc_wr_data | input | 256 | Row data, eight 32-bit columns |
| acc_rd_row | input | 3 | Row to read |
| acc_rd_data | output | 256 | Row contents, eight 32-bit columns |

## Verification
The accumulate path is tried with the full eight-filter range at fixed biases, with a single filter at the top index, and with saturating signed operands and the most negative bias. The last case separates correct sign extension from zero extension. Random commands with random ranges, biases and signedness accumulate on top of each other without clearing, so any error in byte selection, transposition or the permuted row and column layout shows up in the compared 8x8 array. Random back-pressure confirms that stalls only stretch the run. Each rejection cause is applied separately and then followed by a full readback, which shows that nothing was written.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int QUAD  = 4;
  localparam int KW    = 5;
  localparam int OPW   = 10;
  localparam int PRODW = 2 * OPW;
  localparam int SUMW  = PRODW + 2;

  typedef struct packed {
    logic [1:0]    mode;
    logic [KW-1:0] k_first;
    logic [KW-1:0] k_last;
    logic [8:0]    bias_n;
    logic          sgn_n;
    logic [8:0]    bias_w;
    logic          sgn_w;
  } cmd_t;

  // Quad interleave of accumulator rows: swaps the two bits of q.
  function automatic int unsigned lay_perm(input int unsigned q);
    return ((q & 1) << 1) | ((q >> 1) & 1);
  endfunction
endpackage

// File: rtl/conv_cmd_check.sv
module conv_cmd_check
  import conv_pkg::*;
#(
  parameter int WORDS = 8
) (
  input  cmd_t cmd,
  output logic legal
);
  always_comb begin
    legal = 1'b1;
    if (cmd.mode != 2'd0)              legal = 1'b0;
    if (cmd.k_first > cmd.k_last)      legal = 1'b0;
    if (cmd.k_first >= KW'(WORDS))     legal = 1'b0;
    if (cmd.k_last  >= KW'(WORDS))     legal = 1'b0;
  end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int WORDS = 8,
  localparam int RSELW = $clog2(ROWS),
  localparam int WSELW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  cmd_t             cmd,
  input  logic             legal,
  input  logic             rd_ready,
  output logic             busy,
  output logic             done,
  output logic             illegal,
  output logic             fire,
  output logic [RSELW-1:0] row_idx,
  output logic [WSELW-1:0] k_sel,
  output logic [WSELW-1:0] wide_idx,
  output cmd_t             cmd_q
);
  logic             busy_q, done_q, ill_q;
  logic [RSELW-1:0] row_q;
  logic [KW-1:0]    k_q;
  logic [KW-1:0]    k_off;

  assign fire     = busy_q & rd_ready;
  assign busy     = busy_q;
  assign done     = done_q;
  assign illegal  = ill_q;
  assign row_idx  = row_q;
  assign k_sel    = k_q[WSELW-1:0];
  assign k_off    = k_q - cmd_q.k_first;
  assign wide_idx = k_off[WSELW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      row_q  <= '0;
      k_q    <= '0;
      cmd_q  <= '0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          cmd_q <= cmd;
          if (legal) begin
            busy_q <= 1'b1;
            row_q  <= '0;
            k_q    <= cmd.k_first;
          end else begin
            done_q <= 1'b1;
            ill_q  <= 1'b1;
          end
        end
      end else if (fire) begin
        if (row_q == RSELW'(ROWS - 1)) begin
          row_q <= '0;
          if (k_q == cmd_q.k_last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            k_q <= k_q + 1'b1;
          end
        end else begin
          row_q <= row_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/conv_mac_lane.sv
module conv_mac_lane
  import conv_pkg::*;
(
  input  logic [31:0]            nar_word,
  input  logic [31:0]            wide_word,
  input  logic [8:0]             bias_n,
  input  logic [8:0]             bias_w,
  input  logic                   sgn_n,
  input  logic                   sgn_w,
  output logic signed [SUMW-1:0] sum
);
  logic signed [PRODW-1:0] prod [QUAD];

  for (genvar b = 0; b < QUAD; b++) begin : g_byte
    logic signed [OPW-1:0] op_n, op_w;
    assign op_n = $signed({{2{sgn_n & nar_word[8*b+7]}}, nar_word[8*b +: 8]})
                + $signed({bias_n[8], bias_n});
    assign op_w = $signed({{2{sgn_w & wide_word[8*b+7]}}, wide_word[8*b +: 8]})
                + $signed({bias_w[8], bias_w});
    assign prod[b] = op_n * op_w;
  end

  always_comb begin
    sum = '0;
    for (int b = 0; b < QUAD; b++) begin
      sum = sum + SUMW'(prod[b]);
    end
  end
endmodule

// File: rtl/conv_acc_array.sv
module conv_acc_array
  import conv_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int ACCW = 32,
  localparam int RSELW = $clog2(ROWS),
  localparam int CSELW = $clog2(COLS),
  localparam int ROWW  = COLS * ACCW
) (
  input  logic                       clk,
  input  logic                       clear,
  input  logic                       wr_en,
  input  logic [RSELW-1:0]           wr_row,
  input  logic [ROWW-1:0]            wr_data,
  input  logic                       upd_en,
  input  logic [RSELW-1:0]           upd_row,
  input  logic [COLS-1:0][SUMW-1:0]  lane_sum,
  input  logic [RSELW-1:0]           rd_row,
  output logic [ROWW-1:0]            rd_data
);
  logic [ACCW-1:0]  acc_q   [ROWS][COLS];
  logic [RSELW-1:0] tgt_row [COLS];
  logic [CSELW-1:0] tgt_col [COLS];

  // Lane w carries word w of the wide register.
  always_comb begin
    for (int w = 0; w < COLS; w++) begin
      tgt_row[w] = RSELW'((int'(upd_row) / QUAD) * QUAD + int'(lay_perm(w % QUAD)));
      tgt_col[w] = CSELW'((int'(upd_row) % QUAD) * (COLS / QUAD) + w / QUAD);
    end
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          acc_q[r][c] <= '0;
    end else if (wr_en) begin
      for (int c = 0; c < COLS; c++)
        acc_q[wr_row][c] <= wr_data[c*ACCW +: ACCW];
    end else if (upd_en) begin
      for (int w = 0; w < COLS; w++)
        acc_q[tgt_row[w]][tgt_col[w]] <= acc_q[tgt_row[w]][tgt_col[w]]
          + {{(ACCW-SUMW){lane_sum[w][SUMW-1]}}, lane_sum[w]};
    end
  end

  always_comb begin
    for (int c = 0; c < COLS; c++)
      rd_data[c*ACCW +: ACCW] = acc_q[rd_row][c];
  end
endmodule

// File: rtl/conv_acc_engine.sv
module conv_acc_engine
  import conv_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int VBYTES = 32,
  parameter int ACCW   = 32,
  localparam int WORDS = VBYTES / 4,
  localparam int COLS  = WORDS,
  localparam int VECW  = VBYTES * 8,
  localparam int RSELW = $clog2(ROWS),
  localparam int WSELW = $clog2(WORDS),
  localparam int ROWW  = COLS * ACCW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [31:0]      cmd,
  output logic             busy,
  output logic             done,
  output logic             illegal,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [RSELW-1:0] rd_narrow_sel,
  output logic [WSELW-1:0] rd_wide_sel,
  input  logic [VECW-1:0]  rd_narrow_data,
  input  logic [VECW-1:0]  rd_wide_data,
  input  logic             acc_clear,
  input  logic             acc_wr_en,
  input  logic [RSELW-1:0] acc_wr_row,
  input  logic [ROWW-1:0]  acc_wr_data,
  input  logic [RSELW-1:0] acc_rd_row,
  output logic [ROWW-1:0]  acc_rd_data
);
  cmd_t             cmd_in, cmd_q;
  logic             legal, fire;
  logic [WSELW-1:0] k_sel;
  logic [31:0]      nar_word;
  logic [COLS-1:0][SUMW-1:0] lane_sum;

  assign cmd_in = cmd_t'(cmd);

  conv_cmd_check #(.WORDS(WORDS)) u_check (
    .cmd   (cmd_in),
    .legal (legal)
  );

  conv_seq #(.ROWS(ROWS), .WORDS(WORDS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cmd      (cmd_in),
    .legal    (legal),
    .rd_ready (rd_ready),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal),
    .fire     (fire),
    .row_idx  (rd_narrow_sel),
    .k_sel    (k_sel),
    .wide_idx (rd_wide_sel),
    .cmd_q    (cmd_q)
  );

  assign rd_valid = busy;
  assign nar_word = rd_narrow_data[32*k_sel +: 32];

  for (genvar w = 0; w < WORDS; w++) begin : g_lane
    logic signed [SUMW-1:0] s;
    conv_mac_lane u_lane (
      .nar_word  (nar_word),
      .wide_word (rd_wide_data[32*w +: 32]),
      .bias_n    (cmd_q.bias_n),
      .bias_w    (cmd_q.bias_w),
      .sgn_n     (cmd_q.sgn_n),
      .sgn_w     (cmd_q.sgn_w),
      .sum       (s)
    );
    assign lane_sum[w] = s;
  end

  conv_acc_array #(.ROWS(ROWS), .COLS(COLS), .ACCW(ACCW)) u_acc (
    .clk      (clk),
    .clear    (acc_clear & ~busy),
    .wr_en    (acc_wr_en & ~busy),
    .wr_row   (acc_wr_row),
    .wr_data  (acc_wr_data),
    .upd_en   (fire),
    .upd_row  (rd_narrow_sel),
    .lane_sum (lane_sum),
    .rd_row   (acc_rd_row),
    .rd_data  (acc_rd_data)
  );
endmodule

// File: rtl/conv_acc_engine_chk.sv
module conv_acc_engine_chk #(
  parameter int WORDS = 8,
  parameter int RSELW = 3,
  parameter int WSELW = 3,
  parameter int ROWW  = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [31:0]      cmd,
  input logic             busy,
  input logic             done,
  input logic             illegal,
  input logic             rd_ready,
  input logic [RSELW-1:0] rd_narrow_sel,
  input logic [WSELW-1:0] rd_wide_sel,
  input logic             acc_clear,
  input logic             acc_wr_en,
  input logic [RSELW-1:0] acc_rd_row,
  input logic [ROWW-1:0]  acc_rd_data
);
  logic bad_range;
  assign bad_range = (cmd[29:25] > cmd[24:20]) || (cmd[29:25] >= 5'(WORDS))
                  || (cmd[24:20] >= 5'(WORDS));

  assert_illegal_with_done_R2: assert property (@(posedge clk) disable iff (rst)
    illegal |-> done);

  assert_bad_mode_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && cmd[31:30] != 2'd0) |=> (done && illegal));

  assert_bad_range_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && bad_range) |=> (done && illegal));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_first_row_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (rd_narrow_sel == '0 && rd_wide_sel == '0));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_ready) |=> (busy && $stable(rd_narrow_sel) && $stable(rd_wide_sel)));

  assert_idle_acc_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !acc_clear && !acc_wr_en) |=> (!$stable(acc_rd_row) || $stable(acc_rd_data)));

  assert_reset_idle_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !illegal));
endmodule

bind conv_acc_engine conv_acc_engine_chk #(
  .WORDS(WORDS), .RSELW(RSELW), .WSELW(WSELW), .ROWW(ROWW)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .cmd           (cmd),
  .busy          (busy),
  .done          (done),
  .illegal       (illegal),
  .rd_ready      (rd_ready),
  .rd_narrow_sel (rd_narrow_sel),
  .rd_wide_sel   (rd_wide_sel),
  .acc_clear     (acc_clear),
  .acc_wr_en     (acc_wr_en),
  .acc_rd_row    (acc_rd_row),
  .acc_rd_data   (acc_rd_data)
);

// File: tb/conv_acc_engine_tb.sv
`timescale 1ns/1ps
module conv_acc_engine_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [31:0]  cmd = '0;
  logic         busy, done, illegal, rd_valid;
  logic         rd_ready = 1'b1;
  logic [2:0]   rd_narrow_sel, rd_wide_sel;
  logic [255:0] rd_narrow_data, rd_wide_data;
  logic         acc_clear = 1'b0;
  logic         acc_wr_en = 1'b0;
  logic [2:0]   acc_wr_row = '0;
  logic [255:0] acc_wr_data = '0;
  logic [2:0]   acc_rd_row = '0;
  logic [255:0] acc_rd_data;

  logic [7:0] nar [8][32];
  logic [7:0] wid [8][32];
  int exp_acc [8][8];
  int tests = 0;
  int fails = 0;
  localparam int PERM [4] = '{0, 2, 1, 3};

  always #10 clk = ~clk;

  conv_acc_engine u_dut (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .busy(busy), .done(done),
    .illegal(illegal), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_narrow_sel(rd_narrow_sel), .rd_wide_sel(rd_wide_sel),
    .rd_narrow_data(rd_narrow_data), .rd_wide_data(rd_wide_data),
    .acc_clear(acc_clear), .acc_wr_en(acc_wr_en), .acc_wr_row(acc_wr_row),
    .acc_wr_data(acc_wr_data), .acc_rd_row(acc_rd_row), .acc_rd_data(acc_rd_data)
  );

  // Register file model: asynchronous read.
  always_comb begin
    for (int j = 0; j < 32; j++) begin
      rd_narrow_data[8*j +: 8] = nar[rd_narrow_sel][j];
      rd_wide_data[8*j +: 8]   = wid[rd_wide_sel][j];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mk_cmd(input int mode, input int first, input int last,
      input int b1, input bit s1, input int b2, input bit s2);
    return {2'(mode), 5'(first), 5'(last), 9'(b1), s1, 9'(b2), s2};
  endfunction

  function automatic int sx9(input logic [8:0] v);
    return v[8] ? int'(v) - 512 : int'(v);
  endfunction

  function automatic int opv(input logic [7:0] v, input bit s);
    return (s && v[7]) ? int'(v) - 256 : int'(v);
  endfunction

  task automatic model(input logic [31:0] c);
    int first, last, b1, b2;
    bit s1, s2;
    first = int'(c[29:25]); last = int'(c[24:20]);
    b1 = sx9(c[19:11]); s1 = c[10]; b2 = sx9(c[9:1]); s2 = c[0];
    for (int k = first; k <= last; k++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 32; j++) begin
          int d1, d2, r, col;
          d1 = opv(nar[i][4*k + j%4], s1);
          d2 = opv(wid[k-first][j], s2);
          r = (i/4)*4 + PERM[(j/4)%4];
          col = (i%4)*2 + (j/4)/4;
          exp_acc[r][col] = exp_acc[r][col] + (d1 + b1) * (d2 + b2);
        end
  endtask

  task automatic check_acc(input string req);
    for (int r = 0; r < 8; r++) begin
      bit ok = 1'b1;
      logic [31:0] a = '0, e = '0;
      acc_rd_row = 3'(r);
      #1;
      for (int c = 0; c < 8; c++) begin
        if (ok && acc_rd_data[32*c +: 32] !== 32'(exp_acc[r][c])) begin
          ok = 1'b0; a = acc_rd_data[32*c +: 32]; e = 32'(exp_acc[r][c]);
        end
      end
      chk(ok, req, $sformatf("acc row %0d", r), {32'd0, a}, {32'd0, e});
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 32; j++) begin
        nar[i][j] = 8'($urandom);
        wid[i][j] = 8'($urandom);
      end
  endtask

  task automatic run_op(input logic [31:0] c, input bit stall, input bit disturb,
                        output int cyc, output int stalls, output bit ill_seen);
    @(negedge clk);
    cmd = c; start = 1'b1; rd_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; cyc = 0; stalls = 0;
    while (!done && cyc < 5000) begin
      if (disturb && cyc == 2) begin
        start = 1'b1; cmd = 32'h4000_0000;
        acc_clear = 1'b1; acc_wr_en = 1'b1; acc_wr_row = 3'd0; acc_wr_data = '1;
      end else begin
        start = 1'b0; acc_clear = 1'b0; acc_wr_en = 1'b0;
      end
      rd_ready = stall ? (($urandom % 3) != 0) : 1'b1;
      if (busy && !rd_ready) stalls++;
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    ill_seen = illegal;
    start = 1'b0; rd_ready = 1'b1; acc_clear = 1'b0; acc_wr_en = 1'b0;
  endtask

  task automatic legal_run(input logic [31:0] c, input bit stall, input bit disturb,
                           input string req);
    int cyc, stalls, n;
    bit ill;
    n = (int'(c[24:20]) - int'(c[29:25]) + 1) * 8;
    run_op(c, stall, disturb, cyc, stalls, ill);
    chk(done && !ill, req, "done without illegal", {62'd0, done, ill}, 64'd2);
    chk(cyc == n + stalls, stall ? "R8" : "R7", "cycles to done",
        64'(cyc), 64'(n + stalls));
    model(c);
    check_acc(req);
  endtask

  task automatic illegal_run(input logic [31:0] c, input string req);
    int cyc, stalls;
    bit ill;
    run_op(c, 1'b0, 1'b0, cyc, stalls, ill);
    chk(cyc == 0 && ill, req, "illegal pulse timing", 64'(cyc), 64'd0);
    check_acc(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h0c0f_fee5));
    fill_random();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !illegal, "R11", "idle after reset",
        {61'd0, busy, done, illegal}, 64'd0);

    // R9: clear
    acc_clear = 1'b1;
    @(negedge clk);
    acc_clear = 1'b0;
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) exp_acc[r][c] = 0;
    check_acc("R9");

    // R10: row write and read back
    acc_wr_en = 1'b1; acc_wr_row = 3'd3;
    for (int c = 0; c < 8; c++) acc_wr_data[32*c +: 32] = 32'h1000_0000 + 32'(c * 7);
    @(negedge clk);
    acc_wr_en = 1'b0;
    for (int c = 0; c < 8; c++) exp_acc[3][c] = 32'h1000_0000 + c * 7;
    check_acc("R10");

    // R1 R5 R6 R7: full range, fixed biases
    begin
      int cyc, stalls;
      bit ill;
      logic [31:0] c0;
      c0 = mk_cmd(0, 0, 7, 86, 1'b0, 188, 1'b1);
      run_op(c0, 1'b0, 1'b0, cyc, stalls, ill);
      chk(cyc == 64 && !ill, "R7", "full run length", 64'(cyc), 64'd64);
      @(negedge clk);
      chk(!done && !busy, "R7", "done is one cycle", {62'd0, done, busy}, 64'd0);
      model(c0);
      check_acc("R1 R5 R6");
    end

    // R4: extreme signed operands, most negative bias, single top filter
    for (int i = 0; i < 8; i++) for (int j = 0; j < 32; j++) begin
      nar[i][j] = 8'h80; wid[i][j] = 8'h80;
    end
    legal_run(mk_cmd(0, 7, 7, 256, 1'b1, 256, 1'b1), 1'b0, 1'b0, "R4");
    legal_run(mk_cmd(0, 3, 3, 255, 1'b0, 511, 1'b0), 1'b0, 1'b0, "R4");

    // Random legal commands, accumulating, some with back-pressure
    for (int t = 0; t < 12; t++) begin
      int f, l;
      fill_random();
      f = int'($urandom % 8);
      l = f + int'($urandom % (8 - f));
      legal_run(mk_cmd(0, f, l, int'($urandom % 512), 1'($urandom), int'($urandom % 512),
                1'($urandom)), t[0], 1'b0, t[0] ? "R8 R1" : "R5 R6");
    end

    // Rejected commands
    illegal_run(mk_cmd(1, 0, 7, 86, 1'b0, 188, 1'b1), "R2");
    illegal_run(mk_cmd(2, 0, 0, 0, 1'b0, 0, 1'b0), "R2");
    illegal_run(mk_cmd(3, 2, 4, 5, 1'b1, 5, 1'b1), "R2");
    illegal_run(mk_cmd(0, 7, 5, 86, 1'b0, 188, 1'b1), "R3");
    illegal_run(mk_cmd(0, 0, 8, 86, 1'b0, 188, 1'b1), "R3");
    illegal_run(mk_cmd(0, 8, 9, 1, 1'b0, 1, 1'b0), "R3");
    illegal_run(mk_cmd(0, 31, 31, 1, 1'b0, 1, 1'b0), "R3");

    // R7 R9: start, clear and write while busy are ignored
    fill_random();
    legal_run(mk_cmd(0, 1, 6, 300, 1'b1, 17, 1'b0), 1'b0, 1'b1, "R7 R9");

    // R11: reset leaves accumulators
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_acc("R11");

    // R11: reset mid-run returns to idle
    @(negedge clk);
    cmd = mk_cmd(0, 0, 7, 0, 1'b0, 0, 1'b0); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done, "R11", "reset during run", {62'd0, busy, done}, 64'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule